// File: doc/BRIEF.md
# Vector Early-Exit Element Sequencer

This block steps a vector operation through its elements, one element per clock, from index 0 up to the vector length minus one. When the latched mode field selects the data-dependent early-exit mode, the sequencer tests one bit of each element's 4-bit condition result as the element is presented. The condition result comes from an external ALU. If the test fails for an element, that element's result and the results of all higher elements are dropped. The loop then stops and reports a shortened vector length.

The shortened length depends only on which element failed the test. It either includes or excludes the failing element, and it may be zero. If no element fails, or the mode is any other mode, every element is written back and the length is reported unchanged. The ALU stub reads `elem_idx_o` and returns that element's condition bits on `cond_i` in the same cycle.

Top module: `vee_seq`

## Requirements
- R1: After reset, `elem_vld_o`, `wb_en_o` and `done_o` are 0 and `vl_o` is 0.
- R2: When `start_i` arrives with `vl_i`=n>0 and `mode_i[4:3]` is not 2'b01, elements 0 to n-1 are presented on `elem_idx_o` in ascending order, one per cycle, starting the cycle after the start. Each has `wb_en_o`=1. `done_o` pulses the cycle after the last element, with `vl_o`=n.
- R3: A start with `vl_i`=0 presents no element. It pulses `done_o` in the following cycle with `vl_o`=0.
- R4: The early-exit mode is `mode_i[4:3]`=2'b01, and `mode_i[2]` is the expected bit value. With `rc_i`=1, `mode_i[1:0]` picks the tested bit: 0 picks lt (`cond_i[3]`), 1 picks gt (`cond_i[2]`), 2 picks eq (`cond_i[1]`) and 3 picks so (`cond_i[0]`). The test fails when the picked bit differs from `mode_i[2]`.
- R5: In the early-exit mode with `rc_i`=0, the zero test uses the eq bit `cond_i[1]` and fails when it differs from `mode_i[2]`.
- R6: For the failing element, `elem_vld_o`=1 and `wb_en_o`=0. No higher element is presented, and `done_o` pulses in the next cycle.
- R7: After a failure at index i, `vl_o` is i+`mode_i[1]` when `rc_i`=0 and i when `rc_i`=1. This includes 0 when element 0 fails exclusively.
- R8: In the early-exit mode with `rc_i`=0 and `mode_i[0]`=1, `wb_en_o` stays 0 for every element, while the test still ends the loop as in R6 and R7.
- R9: In the early-exit mode, if no element fails, all n elements are presented and `vl_o`=n. The length is never shortened without a failed test.
- R10: `vl_i`, `mode_i` and `rc_i` are captured at start. Later changes to them, and a `start_i` while a run is in progress, have no effect on that run.
- R11: `vl_o` holds its value between runs and changes only in a cycle where `done_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| vl_i | input | $clog2(VL_MAX+1) | Vector length, at most VL_MAX |
| mode_i | input | 5 | Mode field |
| rc_i | input | 1 | Condition-record flag |
| cond_i | input | 4 | Condition bits of the presented element {lt,gt,eq,so} |
| elem_vld_o | output | 1 | An element is presented this cycle |
| elem_idx_o | output | $clog2(VL_MAX+1) | Index of the presented element |
| wb_en_o | output | 1 | Write back the presented element's result |
| done_o | output | 1 | One-cycle completion pulse |
| vl_o | output | $clog2(VL_MAX+1) | Resulting vector length |

## Verification
The hardest situations to reach are a failure at one exact index under one exact combination of tested bit, expected value, inclusive flag and discard flag, and especially a failure at element 0 that gives a zero length. The bench reaches them by sweeping all 32 mode codes and both `rc_i` values over every length from 0 to 8, against condition tables that are all-zero, all-one and arithmetically scrambled. The all-zero and all-one tables force a failure at element 0 or no failure at all, depending on the expected value, and the scrambled tables move the first failure across the indices. During each run the bench also scrambles the capture inputs and sends a stray start while the run is in progress.

// File: rtl/vee_pkg.sv
package vee_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } st_e;

    // Decoded view of the captured mode field
    typedef struct packed {
        logic       ff_en;    // early-exit test active
        logic       inv;      // expected value of the tested bit
        logic [1:0] sel;      // tested bit: 0 lt, 1 gt, 2 eq, 3 so
        logic       incl;     // failing element counts in new length
        logic       discard;  // results never written back
    } ctl_t;

endpackage

// File: rtl/vee_mode_dec.sv
module vee_mode_dec
    import vee_pkg::*;
(
    input  logic [4:0] mode_i,
    input  logic       rc_i,
    output ctl_t       ctl_o
);

    always_comb begin
        ctl_o.ff_en   = (mode_i[4:3] == 2'b01);
        ctl_o.inv     = mode_i[2];
        // without a recorded condition only the zero (eq) test exists
        ctl_o.sel     = rc_i ? mode_i[1:0] : 2'd2;
        ctl_o.incl    = ~rc_i & mode_i[1];
        ctl_o.discard = ctl_o.ff_en & ~rc_i & mode_i[0];
    end

endmodule

// File: rtl/vee_cond_chk.sv
module vee_cond_chk
    import vee_pkg::*;
(
    input  ctl_t       ctl_i,
    input  logic [3:0] cond_i,
    output logic       fail_o
);

    logic [1:0] bitpos;
    logic       picked;

    always_comb begin
        bitpos = 2'd3 - ctl_i.sel;
        picked = cond_i[bitpos];
        fail_o = ctl_i.ff_en & (picked != ctl_i.inv);
    end

endmodule

// File: rtl/vee_seq.sv
module vee_seq
    import vee_pkg::*;
#(
    parameter  int VL_MAX = 64,
    localparam int VLW    = $clog2(VL_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [VLW-1:0] vl_i,
    input  logic [4:0]     mode_i,
    input  logic           rc_i,
    input  logic [3:0]     cond_i,
    output logic           elem_vld_o,
    output logic [VLW-1:0] elem_idx_o,
    output logic           wb_en_o,
    output logic           done_o,
    output logic [VLW-1:0] vl_o
);

    typedef struct packed {
        st_e            st;
        logic [VLW-1:0] idx;
        logic [VLW-1:0] vl;
        logic [4:0]     mode;
        logic           rc;
        logic           done;
        logic [VLW-1:0] vl_res;
    } seq_t;

    seq_t           seq_q, seq_d;
    ctl_t           ctl;
    logic           fail;
    logic           last;
    logic [VLW-1:0] idx_inc;

    vee_mode_dec u_dec (
        .mode_i (seq_q.mode),
        .rc_i   (seq_q.rc),
        .ctl_o  (ctl)
    );

    vee_cond_chk u_test (
        .ctl_i  (ctl),
        .cond_i (cond_i),
        .fail_o (fail)
    );

    always_comb begin
        seq_d   = seq_q;
        seq_d.done = 1'b0;
        idx_inc = seq_q.idx + VLW'(1);
        last    = (idx_inc == seq_q.vl);

        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.vl   = vl_i;
                    seq_d.mode = mode_i;
                    seq_d.rc   = rc_i;
                    seq_d.idx  = '0;
                    if (vl_i == '0) begin
                        seq_d.done   = 1'b1;
                        seq_d.vl_res = '0;
                    end else begin
                        seq_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (fail) begin
                    seq_d.st     = ST_IDLE;
                    seq_d.done   = 1'b1;
                    seq_d.vl_res = seq_q.idx + VLW'(ctl.incl);
                end else if (last) begin
                    seq_d.st     = ST_IDLE;
                    seq_d.done   = 1'b1;
                    seq_d.vl_res = seq_q.vl;
                end else begin
                    seq_d.idx = idx_inc;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign elem_vld_o = (seq_q.st == ST_RUN);
    assign elem_idx_o = seq_q.idx;
    assign wb_en_o    = elem_vld_o & ~fail & ~ctl.discard;
    assign done_o     = seq_q.done;
    assign vl_o       = seq_q.vl_res;

endmodule

// File: rtl/vee_seq_sva.sv
module vee_seq_sva #(
    parameter int VL_MAX = 64,
    parameter int VLW    = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           elem_vld_o,
    input logic [VLW-1:0] elem_idx_o,
    input logic           wb_en_o,
    input logic           done_o,
    input logic [VLW-1:0] vl_o
);

    assert_wb_in_elem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> elem_vld_o);

    assert_idx_ascend_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_vld_o && $past(elem_vld_o)) |-> (elem_idx_o == $past(elem_idx_o) + 1'b1));

    assert_done_no_elem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !elem_vld_o);

    assert_idx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        elem_vld_o |-> (int'(elem_idx_o) < VL_MAX));

    assert_vl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vl_o) |-> done_o);

endmodule

bind vee_seq vee_seq_sva #(.VL_MAX(VL_MAX), .VLW(VLW)) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .elem_vld_o (elem_vld_o),
    .elem_idx_o (elem_idx_o),
    .wb_en_o    (wb_en_o),
    .done_o     (done_o),
    .vl_o       (vl_o)
);

// File: tb/vee_seq_bench.sv
module vee_seq_bench;

    localparam int VLM = 8;
    localparam int VLW = $clog2(VLM + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [VLW-1:0] vl_i = '0;
    logic [4:0]     mode_i = '0;
    logic           rc_i = 1'b0;
    logic [3:0]     cond_i;
    logic           elem_vld_o;
    logic [VLW-1:0] elem_idx_o;
    logic           wb_en_o;
    logic           done_o;
    logic [VLW-1:0] vl_o;

    logic [3:0] pat [0:VLM-1];
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vee_seq #(.VL_MAX(VLM)) u_vee_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .mode_i(mode_i), .rc_i(rc_i), .cond_i(cond_i),
        .elem_vld_o(elem_vld_o), .elem_idx_o(elem_idx_o), .wb_en_o(wb_en_o),
        .done_o(done_o), .vl_o(vl_o)
    );

    // ALU stub: condition bits of the presented element
    always_comb cond_i = (int'(elem_idx_o) < VLM) ? pat[elem_idx_o[2:0]] : 4'h0;

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int s);
        for (int i = 0; i < VLM; i++) begin
            if (s == 0)      pat[i] = 4'h0;
            else if (s == 1) pat[i] = 4'hF;
            else             pat[i] = 4'((s * 37 + i * 11 + s * i * i * 3) ^ (i << (s % 3)));
        end
    endtask

    task automatic run_case(input logic [4:0] m, input logic r, input int n);
        logic ff, inv, incl, disc, bitv;
        int   bp, f, issued, exp_vl;
        logic wb_exp;
        string tag;
        ff   = (m[4:3] == 2'b01);
        inv  = m[2];
        bp   = r ? 3 - int'(m[1:0]) : 1;
        incl = !r && m[1];
        disc = ff && !r && m[0];
        f = n;
        for (int i = 0; i < n; i++) begin
            bitv = pat[i][bp];
            if (ff && (bitv != inv) && f == n) f = i;
        end
        issued = (f < n) ? f + 1 : n;
        exp_vl = (f < n) ? f + int'(incl) : n;

        @(negedge clk);
        start_i = 1'b1; vl_i = VLW'(n); mode_i = m; rc_i = r;
        @(negedge clk);
        start_i = 1'b0;
        // R10: scramble captured inputs during the run
        mode_i = ~m; rc_i = ~r; vl_i = VLW'(n ^ 3);
        for (int k = 0; k < issued; k++) begin
            if (k == 1) start_i = 1'b1;  // R10: stray start while running
            tag = r ? "R4" : "R5";
            chk(elem_vld_o == 1'b1, ff ? tag : "R2", int'(elem_vld_o), 1);
            chk(int'(elem_idx_o) == k, "R2", int'(elem_idx_o), k);
            wb_exp = (k != f) && !disc;
            if (k == f)   tag = "R6";
            else if (disc) tag = "R8";
            else           tag = "R2";
            chk(wb_en_o == wb_exp, tag, int'(wb_en_o), int'(wb_exp));
            @(negedge clk);
            start_i = 1'b0;
        end
        if (n == 0) tag = "R3";
        else if (f < n) tag = "R7";
        else tag = ff ? "R9" : "R2";
        chk(done_o == 1'b1, tag, int'(done_o), 1);
        chk(elem_vld_o == 1'b0, "R6", int'(elem_vld_o), 0);
        chk(int'(vl_o) == exp_vl, tag, int'(vl_o), exp_vl);
        @(negedge clk);
        chk(done_o == 1'b0, "R11", int'(done_o), 0);
        chk(int'(vl_o) == exp_vl, "R11", int'(vl_o), exp_vl);
        chk(elem_vld_o == 1'b0, "R10", int'(elem_vld_o), 0);
    endtask

    initial begin
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(elem_vld_o == 1'b0, "R1", int'(elem_vld_o), 0);
        chk(wb_en_o == 1'b0, "R1", int'(wb_en_o), 0);
        chk(done_o == 1'b0, "R1", int'(done_o), 0);
        chk(vl_o == '0, "R1", int'(vl_o), 0);

        for (int s = 0; s < 6; s++) begin
            fill(s);
            for (int mi = 0; mi < 32; mi++)
                for (int ri = 0; ri < 2; ri++)
                    for (int n = 0; n <= VLM; n++)
                        run_case(5'(mi), 1'(ri), n);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule